// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI shift engine from the module clock. A 13-bit clock-control word carries three fields. Bits 7:0 hold a linear divisor N and bits 11:8 hold an exponent M. Bit 12 selects which law is in force. With bit 12 set, one serial clock period lasts 2*(N+1) module clocks. With bit 12 clear, it lasts 2^(M+1) module clocks. The fastest rate is half the module clock, given by the linear law with N = 0.

The shift engine holds `xfer_active` high for the length of an exchange. The divider then toggles `sclk` with a 50% duty cycle. Each toggle is marked by a one-cycle strobe, `sclk_rise` or `sclk_fall`, which the engine uses to launch and capture data. Outside an exchange the counter is cleared and `sclk` rests at the idle level chosen by `cpol`.

A write to the control word is applied at once while the divider is idle. During an exchange the write is held back until the current serial clock period completes, so no shortened pulse ever reaches the bus.

Top module: `spi_sclk_divider`

## Requirements
- R1: After reset the control word is 0, which selects the power-of-two law with M = 0 (half-period of 1 cycle), and `sclk` equals `cpol` with both strobes low.
- R2: While `xfer_active` is low, `sclk` equals `cpol` from the next cycle on, no strobe is produced, and an exchange that is dropped mid-period returns `sclk` to `cpol` one cycle later.
- R3: With bit 12 = 1, consecutive `sclk` toggles are N+1 module cycles apart, where N is bits 7:0.
- R4: With bit 12 = 0, consecutive `sclk` toggles are 2^M module cycles apart, where M is bits 11:8 (M up to 15).
- R5: The linear law with N = 0 toggles `sclk` on every module cycle, giving half the module clock.
- R6: Each toggle raises exactly one strobe for one cycle, in the first cycle of the new level: `sclk_rise` when `sclk` went from 0 to 1 and `sclk_fall` when it went from 1 to 0. The two strobes are never high together.
- R7: The first toggle of an exchange comes one half-period after `xfer_active` is first sampled high. It is the leading edge: rising when `cpol` = 0 and falling when `cpol` = 1.
- R8: A write during an exchange leaves the current period unchanged. It takes effect from the toggle that ends the period, which is the second toggle of each period, onward.
- R9: A write while idle governs the very next exchange.
- R10: With `cpol` = 1 the idle level is 1 and every period starts with a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| xfer_active | input | 1 | High for the duration of an exchange |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sclk_rise | output | 1 | One-cycle strobe on each rising edge of `sclk` |
| sclk_fall | output | 1 | One-cycle strobe on each falling edge of `sclk` |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent. This brings the full range into reach, from the divide-by-two extreme through the 256-cycle linear maximum to the 32768-cycle half-period at M = 15. A scoreboard predicts the module-cycle stamp and direction of every strobe from the field values. The same prediction covers the point at which a mid-exchange write switches the spacing and the return to idle after an exchange is cut short.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } law_e;
endpackage

// File: rtl/spiclk_cfg_hold.sv
module spiclk_cfg_hold #(
    parameter int CFG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             run,
    input  logic             boundary,
    output logic [CFG_W-1:0] cfg_act
);
    typedef struct packed {
        logic [CFG_W-1:0] act;
        logic [CFG_W-1:0] pend;
        logic             pend_v;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            if (wr_en) begin
                st_d.act    = wr_data;
                st_d.pend_v = 1'b0;
            end else if (st_q.pend_v) begin
                st_d.act    = st_q.pend;
                st_d.pend_v = 1'b0;
            end
        end else if (wr_en) begin
            if (boundary) begin
                st_d.act    = wr_data;
                st_d.pend_v = 1'b0;
            end else begin
                st_d.pend   = wr_data;
                st_d.pend_v = 1'b1;
            end
        end else if (boundary && st_q.pend_v) begin
            st_d.act    = st_q.pend;
            st_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_act = st_q.act;
endmodule

// File: rtl/spiclk_half_limit.sv
module spiclk_half_limit
    import spiclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    parameter int CFG_W = LIN_W + POW_W + 1,
    parameter int CNT_W = 15
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [CNT_W-1:0] limit
);
    localparam int SEL_BIT = LIN_W + POW_W;
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    law_e             law;
    logic [LIN_W-1:0] lin_n;
    logic [POW_W-1:0] pow_m;
    logic [CNT_W:0]   pow_span;
    logic [CNT_W:0]   pow_last;

    always_comb begin
        law      = law_e'(cfg[SEL_BIT]);
        lin_n    = cfg[LIN_W-1:0];
        pow_m    = cfg[SEL_BIT-1:LIN_W];
        pow_span = ONE << pow_m;
        pow_last = pow_span - ONE;
        if (law == LAW_LINEAR) limit = CNT_W'(lin_n);
        else                   limit = pow_last[CNT_W-1:0];
    end
endmodule

// File: rtl/spiclk_phase_gen.sv
module spiclk_phase_gen #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [CNT_W-1:0] limit,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             boundary
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             rise;
        logic             fall;
    } ph_t;

    ph_t  st_d, st_q;
    logic tick;

    always_comb begin
        st_d      = st_q;
        tick      = run && (st_q.cnt == limit);
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end else if (tick) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
            st_d.rise  = cpol ^ st_d.phase;
            st_d.fall  = ~(cpol ^ st_d.phase);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boundary = tick && st_q.phase;
    assign sclk     = cpol ^ st_q.phase;
    assign rise_stb = st_q.rise;
    assign fall_stb = st_q.fall;
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    parameter int CFG_W = LIN_W + POW_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_active,
    input  logic             cpol,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall
);
    localparam int POW_TOP = (2 ** POW_W) - 1;
    localparam int CNT_W   = (POW_TOP > LIN_W) ? POW_TOP : LIN_W;

    logic [CFG_W-1:0] cfg_act;
    logic [CNT_W-1:0] limit;
    logic             boundary;

    spiclk_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_data  (cfg_wdata),
        .run      (xfer_active),
        .boundary (boundary),
        .cfg_act  (cfg_act)
    );

    spiclk_half_limit #(
        .LIN_W (LIN_W),
        .POW_W (POW_W),
        .CFG_W (CFG_W),
        .CNT_W (CNT_W)
    ) u_limit (
        .cfg   (cfg_act),
        .limit (limit)
    );

    spiclk_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (xfer_active),
        .cpol     (cpol),
        .limit    (limit),
        .sclk     (sclk),
        .rise_stb (sclk_rise),
        .fall_stb (sclk_fall),
        .boundary (boundary)
    );
endmodule

// File: rtl/spiclk_div_chk.sv
module spiclk_div_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_active,
    input logic cpol,
    input logic sclk,
    input logic sclk_rise,
    input logic sclk_fall
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (sclk == cpol));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (!sclk_rise && !sclk_fall));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

    // R6
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_rise) |-> (sclk && !$past(sclk)));

    // R6
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_fall) |-> (!sclk && $past(sclk)));
endmodule

bind spi_sclk_divider spiclk_div_chk u_chk (.*);

// File: tb/spi_sclk_divider_bench.sv
module spi_sclk_divider_bench;
    typedef struct {
        int cyc;
        bit rise;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        xfer_active = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk, sclk_rise, sclk_fall;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sclk_divider u_spi_sclk_divider (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .xfer_active (xfer_active), .cpol (cpol), .sclk (sclk),
        .sclk_rise (sclk_rise), .sclk_fall (sclk_fall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: R3 R4 R5 R6 R7 R8 R10 strobe timing and direction
    always @(negedge clk) begin
        if (rst_n && (sclk_rise || sclk_fall)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", cyc, -1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(cyc == it.cyc, "R3/R4 strobe cycle", cyc, it.cyc);
                check(sclk_rise == it.rise && sclk_fall == !it.rise,
                      "R6 strobe kind", int'(sclk_rise), int'(it.rise));
                check(sclk == it.rise, "R7 sclk level", int'(sclk), int'(it.rise));
            end
        end
    end

    task automatic cfg_write(input logic [12:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_edge(input int at, input int k);
        item_t it;
        it.cyc  = at;
        it.rise = ((k % 2) == 0) ? !cpol : cpol;
        exp_q.push_back(it);
    endtask

    task automatic finish_burst(input int last, input string req);
        while (cyc < last) @(negedge clk);
        xfer_active = 1'b0;
        @(negedge clk);
        check(sclk == cpol && !sclk_rise && !sclk_fall, req, int'(sclk), int'(cpol));
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 pending expectations", exp_q.size(), 0);
    endtask

    task automatic run_burst(input int h, input int n);
        int e;
        @(negedge clk);
        e = cyc;
        for (int k = 0; k < n; k++) push_edge(e + (k + 1) * h, k);
        xfer_active = 1'b1;
        finish_burst(e + n * h, "R2 idle after burst");
    endtask

    // R8: write lands during the first half of the first period
    task automatic run_switch(input int h1, input logic [12:0] w, input int h2, input int n);
        int e;
        @(negedge clk);
        e = cyc;
        push_edge(e + h1, 0);
        push_edge(e + 2 * h1, 1);
        for (int k = 2; k < n; k++) push_edge(e + 2 * h1 + (k - 1) * h2, k);
        xfer_active = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        finish_burst(e + 2 * h1 + (n - 2) * h2, "R8 idle after switch");
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 200000);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sclk == 1'b0 && !sclk_rise && !sclk_fall, "R1 reset outputs", int'(sclk), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == cpol, "R1 idle after reset", int'(sclk), int'(cpol));
        // R1: default word gives half-period 1
        run_burst(1, 4);
        // R5 R9: linear N=0
        cfg_write(13'h1000);
        run_burst(1, 6);
        // R3: linear N=3
        cfg_write(13'h1003);
        run_burst(4, 4);
        // R4: power-of-two M=2, M=0, M=3
        cfg_write(13'h0200);
        run_burst(4, 4);
        cfg_write(13'h0000);
        run_burst(1, 3);
        cfg_write(13'h0300);
        run_burst(8, 4);
        // R10 R7: inverted idle level, linear N=1
        @(negedge clk);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R10 idle level high", int'(sclk), 1);
        cfg_write(13'h1001);
        run_burst(2, 4);
        @(negedge clk);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        // R8: mid-run switch linear N=2 -> power-of-two M=1
        cfg_write(13'h1002);
        run_switch(3, 13'h0100, 2, 6);
        // R9: switched word persists into the next exchange
        run_burst(2, 2);
        // R8 with R5: switch into the fastest rate
        cfg_write(13'h1004);
        run_switch(5, 13'h1000, 1, 5);
        // R2: exchange dropped after the leading edge
        cfg_write(13'h1002);
        run_burst(3, 1);
        // R3: linear maximum N=255
        cfg_write(13'h10FF);
        run_burst(256, 2);
        // R4: exponent maximum M=15
        cfg_write(13'h0F00);
        run_burst(32768, 2);
        summary();
    end
endmodule